// File: doc/BRIEF.md
# Physical Page Write-Lock Checker

This block sits between a processor's address path and the physical memory and decides, for every write, whether the running program may change the addressed real page. Real memory is split into 512-word pages. Each page carries a 2-bit lock held in a table inside the block, and the running program holds a 2-bit key in a key register. A write request goes through only when the page's lock opens for the current key. Reads always go through unchanged.

A lock value of zero leaves a page open to every program. A key value of zero is a master key that opens every page. When both are non-zero, the write goes through only if the two values are equal. The check runs on real addresses, after any address translation, and it runs the same way in every processor state.

A denied write never reaches memory. Instead the block raises a one-cycle violation pulse that carries the number of the faulting page. Supervisory code fills the lock table through a dedicated load port and sets the key through a separate load port. All outputs are registered, so each request is answered one cycle after it is presented.

Top module: `pwl_write_guard`

## Requirements
- R1: Reset (synchronous, active high) sets every page lock to 0 and the key to 0, and drives mem_valid, mem_we and viol low; after reset, a write with any key to any page is forwarded.
- R2: A write to a page whose lock is 0 is forwarded to memory (mem_valid=1, mem_we=1, viol=0) whatever the key.
- R3: A write made while the key is 0 is forwarded to memory whatever the page's lock.
- R4: When lock and key are both non-zero, a write is forwarded only if they are equal. Otherwise mem_valid and mem_we stay 0 and viol is 1 for that response cycle.
- R5: A read (req_write=0) is always forwarded with mem_valid=1, mem_we=0 and viol=0, whatever the lock and key.
- R6: The page number is req_addr[16:9]. The low 9 bits select a word within the page. On a violation, viol_page equals req_addr[16:9] of the denied request.
- R7: A lock load (lock_ld=1) writes lock_ld_val into the entry for lock_ld_page only. A key load (key_ld=1) replaces the key. Both loads take effect from the next cycle.
- R8: If a lock load and a request address the same page in the same cycle, the request is checked against the lock value held before the load.
- R9: A request presented at a clock edge is answered at the next edge: forwarded requests carry the same mem_addr and mem_wdata, and viol lasts one cycle per denied request.
- R10: In a cycle with no request (req_valid=0), the following response cycle has mem_valid=0 and viol=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_ld | input | 1 | Load the program key |
| key_ld_val | input | 2 | New key value |
| lock_ld | input | 1 | Load one page lock |
| lock_ld_page | input | 8 | Page whose lock is loaded |
| lock_ld_val | input | 2 | New lock value |
| req_valid | input | 1 | Memory request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Real word address |
| req_wdata | input | 32 | Write data |
| mem_valid | output | 1 | Request forwarded to memory |
| mem_we | output | 1 | Write strobe to memory |
| mem_addr | output | 17 | Forwarded word address |
| mem_wdata | output | 32 | Forwarded write data |
| viol | output | 1 | One-cycle write-lock violation pulse |
| viol_page | output | 8 | Page of the denied write |

## Verification
The assertions assume that request and load inputs carry known values at every sampled edge, and that the key observed in a request cycle is the one the decision uses. In other words, a key load only affects requests in later cycles. The bench drives all inputs on the falling edge and returns them to idle between operations, so every request sees settled lock and key state. The one exception is the directed case where a lock load and a request are deliberately presented together to exercise R8.

// File: rtl/pwl_pkg.sv
package pwl_pkg;

    localparam int ADDR_W     = 17;
    localparam int PAGE_SHIFT = 9;
    localparam int PAGE_W     = ADDR_W - PAGE_SHIFT;
    localparam int NUM_PAGES  = 1 << PAGE_W;
    localparam int LOCK_W     = 2;
    localparam int DATA_W     = 32;

    typedef logic [LOCK_W-1:0] lock_t;
    typedef logic [PAGE_W-1:0] page_t;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } req_t;

    typedef enum logic [1:0] {
        VD_IDLE = 2'd0,
        VD_PASS = 2'd1,
        VD_DENY = 2'd2
    } verdict_e;

    function automatic page_t page_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:PAGE_SHIFT];
    endfunction

    function automatic logic lock_opens(input lock_t lock, input lock_t key);
        return (lock == '0) || (key == '0) || (lock == key);
    endfunction

endpackage

// File: rtl/pwl_lock_table.sv
module pwl_lock_table #(
    parameter int PAGE_W = 8,
    parameter int LOCK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_page,
    input  logic [LOCK_W-1:0] wr_lock,
    input  logic [PAGE_W-1:0] rd_page,
    output logic [LOCK_W-1:0] rd_lock
);
    localparam int PAGES = 1 << PAGE_W;

    logic [LOCK_W-1:0] lock_q [PAGES];

    for (genvar g = 0; g < PAGES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                lock_q[g] <= '0;
            end else if (wr_en && (wr_page == PAGE_W'(g))) begin
                lock_q[g] <= wr_lock;
            end
        end
    end

    // Read returns the stored value; a same-cycle load lands at the edge.
    assign rd_lock = lock_q[rd_page];

endmodule

// File: rtl/pwl_key_reg.sv
module pwl_key_reg #(
    parameter int LOCK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [LOCK_W-1:0] ld_val,
    output logic [LOCK_W-1:0] key
);
    always_ff @(posedge clk) begin
        if (rst) begin
            key <= '0;
        end else if (ld) begin
            key <= ld_val;
        end
    end
endmodule

// File: rtl/pwl_judge.sv
module pwl_judge
    import pwl_pkg::*;
(
    input  req_t     req,
    input  lock_t    lock,
    input  lock_t    key,
    output verdict_e verdict
);
    always_comb begin
        if (!req.valid) begin
            verdict = VD_IDLE;
        end else if (!req.write) begin
            verdict = VD_PASS;
        end else if (lock_opens(lock, key)) begin
            verdict = VD_PASS;
        end else begin
            verdict = VD_DENY;
        end
    end
endmodule

// File: rtl/pwl_out_stage.sv
module pwl_out_stage
    import pwl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  req_t              req,
    input  verdict_e          verdict,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              viol,
    output logic [PAGE_W-1:0] viol_page
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_valid <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            viol      <= 1'b0;
            viol_page <= '0;
        end else begin
            mem_valid <= (verdict == VD_PASS);
            mem_we    <= (verdict == VD_PASS) && req.write;
            viol      <= (verdict == VD_DENY);
            if (verdict == VD_PASS) begin
                mem_addr  <= req.addr;
                mem_wdata <= req.data;
            end
            if (verdict == VD_DENY) begin
                viol_page <= page_of(req.addr);
            end
        end
    end
endmodule

// File: rtl/pwl_write_guard.sv
module pwl_write_guard
    import pwl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              key_ld,
    input  logic [LOCK_W-1:0] key_ld_val,
    input  logic              lock_ld,
    input  logic [PAGE_W-1:0] lock_ld_page,
    input  logic [LOCK_W-1:0] lock_ld_val,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              viol,
    output logic [PAGE_W-1:0] viol_page
);
    req_t     req;
    lock_t    page_lock;
    lock_t    cur_key;
    verdict_e verdict;

    assign req = '{valid: req_valid, write: req_write, addr: req_addr, data: req_wdata};

    pwl_lock_table #(.PAGE_W(PAGE_W), .LOCK_W(LOCK_W)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (lock_ld),
        .wr_page (lock_ld_page),
        .wr_lock (lock_ld_val),
        .rd_page (page_of(req_addr)),
        .rd_lock (page_lock)
    );

    pwl_key_reg #(.LOCK_W(LOCK_W)) u_key (
        .clk    (clk),
        .rst    (rst),
        .ld     (key_ld),
        .ld_val (key_ld_val),
        .key    (cur_key)
    );

    pwl_judge u_judge (
        .req     (req),
        .lock    (page_lock),
        .key     (cur_key),
        .verdict (verdict)
    );

    pwl_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .verdict   (verdict),
        .mem_valid (mem_valid),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .viol      (viol),
        .viol_page (viol_page)
    );
endmodule

// File: rtl/pwl_write_guard_chk.sv
module pwl_write_guard_chk
    import pwl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [LOCK_W-1:0] cur_key,
    input logic              mem_valid,
    input logic              mem_we,
    input logic              viol,
    input logic [PAGE_W-1:0] viol_page
);
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_valid, viol})); // R4

    AST_DENY_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        viol |-> !mem_we); // R4

    AST_READ_PASSES: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> (mem_valid && !mem_we && !viol)); // R5

    AST_MASTER_KEY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && cur_key == '0) |=> (mem_we && !viol)); // R3

    AST_VIOL_PAGE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> (!viol || viol_page == $past(req_addr[ADDR_W-1:PAGE_SHIFT]))); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!mem_valid && !viol)); // R10
endmodule

bind pwl_write_guard pwl_write_guard_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .cur_key   (cur_key),
    .mem_valid (mem_valid),
    .mem_we    (mem_we),
    .viol      (viol),
    .viol_page (viol_page)
);

// File: tb/tb_pwl_write_guard.sv
module tb_pwl_write_guard;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    // {lock[14:13], key[12:11], page[10:3], write[2], exp_we[1], exp_viol[0]}
    localparam logic [14:0] VEC [NV] = '{
        {2'd0, 2'd3, 8'd5,   1'b1, 1'b1, 1'b0},  // R2
        {2'd1, 2'd0, 8'd6,   1'b1, 1'b1, 1'b0},  // R3
        {2'd2, 2'd2, 8'd7,   1'b1, 1'b1, 1'b0},  // R4 match
        {2'd2, 2'd1, 8'd8,   1'b1, 1'b0, 1'b1},  // R4 mismatch
        {2'd3, 2'd1, 8'd255, 1'b1, 1'b0, 1'b1},  // R4 top page
        {2'd1, 2'd1, 8'd0,   1'b1, 1'b1, 1'b0},  // R4 page 0
        {2'd3, 2'd2, 8'd9,   1'b0, 1'b0, 1'b0},  // R5 read
        {2'd3, 2'd3, 8'd200, 1'b1, 1'b1, 1'b0},  // R4
        {2'd1, 2'd3, 8'd10,  1'b1, 1'b0, 1'b1},  // R4
        {2'd0, 2'd0, 8'd11,  1'b1, 1'b1, 1'b0},  // R2/R3
        {2'd3, 2'd0, 8'd12,  1'b1, 1'b1, 1'b0},  // R3
        {2'd1, 2'd2, 8'd128, 1'b0, 1'b0, 1'b0}   // R5 read
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        key_ld = 1'b0;
    logic [1:0]  key_ld_val = '0;
    logic        lock_ld = 1'b0;
    logic [7:0]  lock_ld_page = '0;
    logic [1:0]  lock_ld_val = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        mem_valid, mem_we, viol;
    logic [16:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [7:0]  viol_page;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwl_write_guard dut (
        .clk(clk), .rst(rst),
        .key_ld(key_ld), .key_ld_val(key_ld_val),
        .lock_ld(lock_ld), .lock_ld_page(lock_ld_page), .lock_ld_val(lock_ld_val),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .viol(viol), .viol_page(viol_page)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load_lock(input logic [7:0] pg, input logic [1:0] v);
        @(negedge clk);
        lock_ld = 1'b1; lock_ld_page = pg; lock_ld_val = v;
        @(negedge clk);
        lock_ld = 1'b0;
    endtask

    task automatic load_key(input logic [1:0] v);
        @(negedge clk);
        key_ld = 1'b1; key_ld_val = v;
        @(negedge clk);
        key_ld = 1'b0;
    endtask

    // Drive a request for one cycle; outputs are sampled on the next falling edge.
    task automatic request(input logic wr, input logic [16:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 mem_valid after reset", mem_valid, 0);
        chk("R1 viol after reset", viol, 0);
        chk("R1 mem_we after reset", mem_we, 0);
        rst = 1'b0;

        // R1: locks cleared by reset, so a non-zero key still writes
        load_key(2'd3);
        request(1'b1, {8'd77, 9'd3}, 32'hA5A5_0001);
        chk("R1 write after reset forwarded", mem_we, 1);
        chk("R1 no viol after reset", viol, 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  lk, ky;
            logic [7:0]  pg;
            logic        wr, ewe, evl;
            logic [16:0] a;
            {lk, ky, pg, wr, ewe, evl} = VEC[i];
            a = {pg, 9'(i * 37 + 1)};
            load_lock(pg, lk);
            load_key(ky);
            request(wr, a, 32'h1000_0000 + i);
            chk($sformatf("R4 vec%0d mem_we", i), mem_we, ewe);
            chk($sformatf("R4 vec%0d viol", i), viol, evl);
            chk($sformatf("R5 vec%0d mem_valid", i), mem_valid, !evl);
            if (evl) chk($sformatf("R6 vec%0d viol_page", i), viol_page, pg);
            else begin
                chk($sformatf("R9 vec%0d mem_addr", i), mem_addr, a);
                chk($sformatf("R9 vec%0d mem_wdata", i), mem_wdata, 32'h1000_0000 + i);
            end
        end

        // R6: page boundary at word address bit 9
        load_lock(8'd3, 2'd1);
        load_key(2'd2);
        request(1'b1, 17'h005FF, 32'h0);
        chk("R6 last word of page 2 passes", mem_we, 1);
        request(1'b1, 17'h00600, 32'h0);
        chk("R6 first word of page 3 denied", viol, 1);
        chk("R6 viol_page is 3", viol_page, 8'd3);
        // R9: violation lasts one cycle
        @(negedge clk);
        chk("R9 viol single cycle", viol, 0);
        chk("R10 idle mem_valid", mem_valid, 0);

        // R7: neighbouring page untouched by a lock load
        load_lock(8'd30, 2'd1);
        request(1'b1, {8'd31, 9'd0}, 32'h0);
        chk("R7 neighbour page stays open", mem_we, 1);
        request(1'b1, {8'd30, 9'd0}, 32'h0);
        chk("R7 loaded page denies", viol, 1);

        // R8: lock load and request on same page in same cycle
        @(negedge clk);
        lock_ld = 1'b1; lock_ld_page = 8'd20; lock_ld_val = 2'd1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = {8'd20, 9'd5};
        @(negedge clk);
        lock_ld = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        chk("R8 same-cycle uses old lock", mem_we, 1);
        chk("R8 same-cycle no viol", viol, 0);
        request(1'b1, {8'd20, 9'd5}, 32'h0);
        chk("R8 new lock applies next", viol, 1);

        // R3 after locks set: master key opens page 20
        load_key(2'd0);
        request(1'b1, {8'd20, 9'd5}, 32'h0);
        chk("R3 master key opens locked page", mem_we, 1);

        // R1: reset mid-run clears locks and key
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        load_key(2'd2);
        request(1'b1, {8'd30, 9'd0}, 32'h0);
        chk("R1 reset clears locks", mem_we, 1);
        chk("R1 reset clears locks viol", viol, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule